// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target with Key-Gated Address Code

This block is the target side of a two-wire serial memory. It watches an open-drain clock and data pair, answers to a 7-bit device address, and gives access to a byte-wide memory through a 16-bit address pointer. A master can write single bytes or runs of bytes, set the pointer and then read from it after a repeated start, or read straight from wherever the pointer was left. The pointer advances after every byte. It wraps from 0xFFFF to 0x0000. Storage is indexed by the low `MEM_AW` pointer bits.

The device address has two parts. The upper four bits are a fixed type field, 1010. The lower three bits are a code that can be changed while the chip runs. A host-side 8-bit key register controls that change. If the key holds 0x5F, a byte write of 0x00..0x07 to memory address 0xFF09 queues a new code. The new code is adopted at the stop condition that closes the frame. Any other write to that address is an ordinary memory write.

Both bus lines pass through a synchronizer clocked by a system clock much faster than the bus clock. Edge events and start/stop events are taken from the synchronized copies.

Top module: `eeprom_i2c_target`

## Requirements
- R1: After reset the key register reads 0xFF, the address code is 000, and SDA is released (`sda_oe` = 0).
- R2: The device byte is 7 address bits followed by the R/W bit (1 = read). The target pulls SDA low in the ninth clock only when the address equals {1010, code}. Any other address gets no ACK, and the target ignores the bus until the next start.
- R3: In a write frame, the device byte is followed by the pointer high byte, then the pointer low byte, then data bytes. Every byte is ACKed. Each data byte is stored at the pointer, and the pointer then increments.
- R4: A read begins with a repeated start after an address phase. It returns the byte at the pointer and advances the pointer after each byte. The pointer wraps from 0xFFFF to 0x0000.
- R5: A read frame with no address phase returns data from the current pointer, which is the address after the last byte transferred.
- R6: A master NACK after a read byte ends the transfer. SDA stays released, and further clocks are ignored until a start.
- R7: The host can write the 8-bit key register, and it reads back the value written.
- R8: With key 0x5F, a data byte of 0x00..0x07 written to address 0xFF09 becomes the new address code. Afterwards the old address gets no ACK and the new one does.
- R9: A write to 0xFF09 with a key other than 0x5F, or with a data value above 0x07, is ACKed and stored as memory data but leaves the address code unchanged.
- R10: A new code takes effect only at a stop. Until that stop, including after a repeated start, the old address still answers.
- R11: A start seen partway through a byte abandons the byte without storing it and begins a new device byte.
- R12: A stop seen partway through a byte abandons the byte without storing it and returns the target to idle.
- R13: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| key_we | input | 1 | Host write strobe for the key register |
| key_wdata | input | KEY_W | Host write data for the key register |
| key_rdata | output | KEY_W | Current key register value |

## Verification
Bus edges reach the control logic `SYNC_STAGES`+1 system clocks after they occur at the pin. The ACK drive and each read bit therefore appear a few clocks after the SCL fall that requests them. The bench waits a quarter bus period after every SCL edge before it changes SDA. It samples SDA a quarter period into the SCL high phase, when every response is long settled. The key register is checked one clock after the write strobe. An address-code change is checked only through the ACK of a device byte in a frame started after the stop that commits it. The SDA-drive rule is watched on every falling system clock edge for the whole run.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RX,
      PH_RX_ACK,
      PH_TX,
      PH_TX_ACK
   } phase_t;

   typedef enum logic [1:0] {
      BY_DEV,
      BY_PTR_HI,
      BY_PTR_LO,
      BY_DATA
   } byte_role_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_p, sda_p;
   logic scl_q, sda_q;

   if (STAGES < 1 || STAGES > 4) begin : g_bad_stages
      $error("i2c_line_sync: STAGES must be 1..4");
   end

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
         end else begin
            scl_p <= scl_i;
            sda_p <= sda_i;
         end
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
         end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_i};
            sda_p <= {sda_p[STAGES-2:0], sda_i};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_p[STAGES-1];
         sda_q <= sda_p[STAGES-1];
      end
   end

   assign scl_s     = scl_p[STAGES-1];
   assign sda_s     = sda_p[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eeprom_key_reg.sv
module eeprom_key_reg #(
   parameter int              W   = 8,
   parameter logic [W-1:0]    RST = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("eeprom_key_reg: W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST;
      else if (we) q <= wdata;
   end

   a_r7_key_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));
endmodule

// File: rtl/eeprom_byte_mem.sv
module eeprom_byte_mem #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   localparam int DEPTH = 1 << AW;

   if (AW < 1 || AW > 12) begin : g_bad_aw
      $error("eeprom_byte_mem: AW must be 1..12");
   end

   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
   import eeprom_i2c_pkg::*;
#(
   parameter int                MEM_AW      = 8,
   parameter int                CODE_W      = 3,
   parameter int                SYNC_STAGES = 2,
   parameter logic [6:0]        DEV_BASE    = 7'b1010000,
   parameter int                KEY_W       = 8,
   parameter logic [KEY_W-1:0]  UNLOCK_KEY  = 8'h5F,
   parameter logic [15:0]       PROG_ADDR   = 16'hFF09
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe,
   input  logic             key_we,
   input  logic [KEY_W-1:0] key_wdata,
   output logic [KEY_W-1:0] key_rdata
);
   localparam int PTR_W = 16;

   if (CODE_W < 1 || CODE_W > 6) begin : g_bad_code
      $error("eeprom_i2c_target: CODE_W must be 1..6");
   end
   if (MEM_AW > PTR_W) begin : g_bad_mem
      $error("eeprom_i2c_target: MEM_AW exceeds pointer width");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic [KEY_W-1:0] key_q;
   logic [7:0]       mem_rd;
   logic             mem_we;

   phase_t            phase;
   byte_role_t        role;
   logic              go_tx, byte_full, mst_ack, pend_vld;
   logic [2:0]        bit_cnt;
   logic [7:0]        shreg;
   logic [PTR_W-1:0]  ptr;
   logic [CODE_W-1:0] addr_code, pend_code;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   eeprom_key_reg #(.W(KEY_W), .RST('1)) u_key (
      .clk(clk), .rst_n(rst_n), .we(key_we), .wdata(key_wdata), .q(key_q));

   eeprom_byte_mem #(.AW(MEM_AW)) u_mem (
      .clk(clk), .we(mem_we), .waddr(ptr[MEM_AW-1:0]), .wdata(shreg),
      .raddr(ptr[MEM_AW-1:0]), .rdata(mem_rd));

   assign key_rdata = key_q;

   logic dev_hit, prog_hit;
   assign dev_hit  = (shreg[7:CODE_W+1] == DEV_BASE[6:CODE_W]) &&
                     (shreg[CODE_W:1] == addr_code);
   assign prog_hit = (ptr == PROG_ADDR) && (key_q == UNLOCK_KEY) &&
                     ((shreg >> CODE_W) == 8'd0);
   assign mem_we   = (phase == PH_RX) && scl_fall && byte_full &&
                     (role == BY_DATA) && !start_det && !stop_det;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         role      <= BY_DEV;
         go_tx     <= 1'b0;
         byte_full <= 1'b0;
         mst_ack   <= 1'b0;
         pend_vld  <= 1'b0;
         bit_cnt   <= '0;
         shreg     <= '0;
         ptr       <= '0;
         addr_code <= '0;
         pend_code <= '0;
         sda_oe    <= 1'b0;
      end else if (start_det) begin
         phase     <= PH_RX;
         role      <= BY_DEV;
         bit_cnt   <= '0;
         byte_full <= 1'b0;
         go_tx     <= 1'b0;
         sda_oe    <= 1'b0;
      end else if (stop_det) begin
         phase  <= PH_IDLE;
         sda_oe <= 1'b0;
         if (pend_vld) begin
            addr_code <= pend_code;
            pend_vld  <= 1'b0;
         end
      end else begin
         case (phase)
            PH_RX: begin
               if (scl_rise && !byte_full) begin
                  shreg   <= {shreg[6:0], sda_s};
                  bit_cnt <= bit_cnt + 3'd1;
                  if (bit_cnt == 3'd7) byte_full <= 1'b1;
               end else if (scl_fall && byte_full) begin
                  byte_full <= 1'b0;
                  phase     <= PH_RX_ACK;
                  sda_oe    <= 1'b1;
                  case (role)
                     BY_DEV: begin
                        if (dev_hit) begin
                           go_tx <= shreg[0];
                           role  <= BY_PTR_HI;
                        end else begin
                           phase  <= PH_IDLE;
                           sda_oe <= 1'b0;
                        end
                     end
                     BY_PTR_HI: begin
                        ptr[15:8] <= shreg;
                        role      <= BY_PTR_LO;
                     end
                     BY_PTR_LO: begin
                        ptr[7:0] <= shreg;
                        role     <= BY_DATA;
                     end
                     default: begin
                        ptr <= ptr + 16'd1;
                        if (prog_hit) begin
                           pend_code <= shreg[CODE_W-1:0];
                           pend_vld  <= 1'b1;
                        end
                     end
                  endcase
               end
            end
            PH_RX_ACK, PH_TX_ACK: begin
               if (phase == PH_TX_ACK && scl_rise) begin
                  mst_ack <= ~sda_s;
               end else if (scl_fall) begin
                  if ((phase == PH_RX_ACK && go_tx) || (phase == PH_TX_ACK && mst_ack)) begin
                     shreg   <= mem_rd;
                     ptr     <= ptr + 16'd1;
                     sda_oe  <= ~mem_rd[7];
                     bit_cnt <= '0;
                     go_tx   <= 1'b0;
                     phase   <= PH_TX;
                  end else if (phase == PH_RX_ACK) begin
                     sda_oe <= 1'b0;
                     phase  <= PH_RX;
                  end else begin
                     sda_oe <= 1'b0;
                     phase  <= PH_IDLE;
                  end
               end
            end
            PH_TX: begin
               if (scl_rise) begin
                  bit_cnt <= bit_cnt + 3'd1;
                  if (bit_cnt == 3'd7) byte_full <= 1'b1;
               end else if (scl_fall) begin
                  if (byte_full) begin
                     byte_full <= 1'b0;
                     sda_oe    <= 1'b0;
                     phase     <= PH_TX_ACK;
                  end else begin
                     shreg  <= {shreg[6:0], 1'b0};
                     sda_oe <= ~shreg[6];
                  end
               end
            end
            default: ;
         endcase
      end
   end

   a_r13_drive_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_s);
   a_r6_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE) |-> !sda_oe);
   a_r11_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (phase == PH_RX && bit_cnt == 3'd0 && !sda_oe));
   a_r10_code_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(addr_code) |-> $past(stop_det));
   a_r9_pending_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_vld) |-> ($past(key_q) == UNLOCK_KEY));
endmodule

// File: tb/eeprom_i2c_target_tb.sv
`timescale 1ns/1ps
module eeprom_i2c_target_tb;
   localparam int Q = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m_low = 1'b0, key_we = 1'b0;
   logic [7:0] key_wdata = 8'h00;
   logic [7:0] key_rdata;
   logic sda_oe, sda_bus, prev_oe = 1'b0;
   int n_tests = 0, n_fail = 0, r13_bad = 0;
   logic [7:0] model [256];

   always #2.5 clk = ~clk;
   assign sda_bus = ~(sda_m_low | sda_oe);

   eeprom_i2c_target u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
      .key_we(key_we), .key_wdata(key_wdata), .key_rdata(key_rdata));

   // R13 monitor: SDA drive may change only while SCL is low
   always @(negedge clk) begin
      if (rst_n && scl_m && (sda_oe !== prev_oe)) r13_bad++;
      prev_oe = sda_oe;
   end

   task automatic wq(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] dev_byte(logic [2:0] code, logic rd);
      return {4'b1010, code, rd};
   endfunction

   task automatic bus_start;
      sda_m_low = 1'b0; wq(Q); scl_m = 1'b1; wq(Q);
      sda_m_low = 1'b1; wq(Q); scl_m = 1'b0; wq(Q);
   endtask

   task automatic bus_stop;
      sda_m_low = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m_low = 1'b0; wq(Q);
   endtask

   task automatic put_bit(logic b);
      sda_m_low = ~b; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
   endtask

   task automatic get_bit(output logic b);
      sda_m_low = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); b = sda_bus;
      wq(Q); scl_m = 1'b0; wq(Q);
   endtask

   task automatic put_byte(logic [7:0] d, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(d[i]);
      get_bit(b);
      ack = ~b;
   endtask

   task automatic get_byte(logic ack, output logic [7:0] d);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         d[i] = b;
      end
      put_bit(~ack);
   endtask

   task automatic key_write(logic [7:0] v);
      @(posedge clk); #1 key_we = 1'b1; key_wdata = v;
      @(posedge clk); #1 key_we = 1'b0;
   endtask

   task automatic addr_phase(logic [2:0] code, logic [15:0] a, output logic ok);
      logic a0, a1, a2;
      bus_start;
      put_byte(dev_byte(code, 1'b0), a0);
      put_byte(a[15:8], a1);
      put_byte(a[7:0], a2);
      ok = a0 & a1 & a2;
   endtask

   task automatic write1(logic [2:0] code, logic [15:0] a, logic [7:0] d, output logic ok);
      logic a3;
      addr_phase(code, a, ok);
      put_byte(d, a3);
      bus_stop;
      ok = ok & a3;
   endtask

   task automatic read1(logic [2:0] code, logic [15:0] a, output logic [7:0] d, output logic ok);
      logic a3;
      addr_phase(code, a, ok);
      bus_start;
      put_byte(dev_byte(code, 1'b1), a3);
      get_byte(1'b0, d);
      bus_stop;
      ok = ok & a3;
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic ok, ack;
      logic [7:0] d;
      logic [15:0] addrs [16];
      int unused_seed;
      unused_seed = $urandom(32'h00C0FFEE);

      wq(5); rst_n = 1'b1; wq(3);
      check("R1 key reset", {8'h0, key_rdata}, 16'h00FF);
      check("R1 sda released", {15'h0, sda_oe}, 16'h0);

      key_write(8'h3C); wq(1);
      check("R7 key readback", {8'h0, key_rdata}, 16'h003C);
      key_write(8'h00); wq(1);
      check("R7 key readback 2", {8'h0, key_rdata}, 16'h0000);

      // R2: matching and non-matching addresses
      bus_start; put_byte(dev_byte(3'd0, 1'b0), ack); bus_stop;
      check("R2 match ack", {15'h0, ack}, 16'h1);
      bus_start; put_byte(dev_byte(3'd1, 1'b0), ack); bus_stop;
      check("R2 code mismatch nack", {15'h0, ack}, 16'h0);
      bus_start; put_byte(8'h58, ack); bus_stop;
      check("R2 type mismatch nack", {15'h0, ack}, 16'h0);

      // R3 / R4: multi-byte write, then random read with sequential follow-on
      addr_phase(3'd0, 16'h1234, ok);
      check("R3 address phase acks", {15'h0, ok}, 16'h1);
      put_byte(8'hA5, ack); check("R3 data ack 0", {15'h0, ack}, 16'h1);
      put_byte(8'h5A, ack); check("R3 data ack 1", {15'h0, ack}, 16'h1);
      put_byte(8'h3C, ack); check("R3 data ack 2", {15'h0, ack}, 16'h1);
      bus_stop;
      addr_phase(3'd0, 16'h1234, ok);
      bus_start; put_byte(dev_byte(3'd0, 1'b1), ack);
      check("R4 read device ack", {15'h0, ack}, 16'h1);
      get_byte(1'b1, d); check("R4 seq read 0", {8'h0, d}, 16'h00A5);
      get_byte(1'b1, d); check("R4 seq read 1", {8'h0, d}, 16'h005A);
      get_byte(1'b0, d); check("R4 seq read 2", {8'h0, d}, 16'h003C);
      bus_stop;

      // R2: a non-matching frame must not store its data
      bus_start; put_byte(dev_byte(3'd2, 1'b0), ack);
      put_byte(8'h12, ack); put_byte(8'h34, ack); put_byte(8'hEE, ack); bus_stop;
      read1(3'd0, 16'h1234, d, ok);
      check("R2 ignored frame leaves data", {8'h0, d}, 16'h00A5);

      // R5: current-address read
      write1(3'd0, 16'h2000, 8'h11, ok);
      write1(3'd0, 16'h2001, 8'h22, ok);
      read1(3'd0, 16'h2000, d, ok);
      check("R5 setup read", {8'h0, d}, 16'h0011);
      bus_start; put_byte(dev_byte(3'd0, 1'b1), ack); get_byte(1'b0, d); bus_stop;
      check("R5 current address read", {8'h0, d}, 16'h0022);

      // R4: pointer wrap from 0xFFFF to 0x0000
      write1(3'd0, 16'hFFFF, 8'h77, ok);
      write1(3'd0, 16'h0000, 8'h88, ok);
      addr_phase(3'd0, 16'hFFFF, ok);
      bus_start; put_byte(dev_byte(3'd0, 1'b1), ack);
      get_byte(1'b1, d); check("R4 read at 0xFFFF", {8'h0, d}, 16'h0077);
      get_byte(1'b0, d); check("R4 wrapped read", {8'h0, d}, 16'h0088);
      // R6: after NACK the target no longer drives SDA
      begin
         int ones = 0;
         logic b;
         for (int i = 0; i < 9; i++) begin
            get_bit(b);
            if (b) ones++;
         end
         check("R6 released after nack", 16'(ones), 16'd9);
      end
      bus_stop;

      // R9: wrong key, then out-of-range value
      write1(3'd0, 16'hFF09, 8'h05, ok);
      check("R9 locked write acks", {15'h0, ok}, 16'h1);
      read1(3'd0, 16'hFF09, d, ok);
      check("R9 locked write stored", {8'h0, d}, 16'h0005);
      check("R9 code unchanged (key)", {15'h0, ok}, 16'h1);
      key_write(8'h5F);
      write1(3'd0, 16'hFF09, 8'h0C, ok);
      check("R9 big value acks", {15'h0, ok}, 16'h1);
      read1(3'd0, 16'hFF09, d, ok);
      check("R9 big value stored", {8'h0, d}, 16'h000C);
      check("R9 code unchanged (value)", {15'h0, ok}, 16'h1);

      // R8 / R10: reprogram to code 6, check old code until the stop
      addr_phase(3'd0, 16'hFF09, ok);
      put_byte(8'h06, ack);
      check("R8 program write ack", {15'h0, ack & ok}, 16'h1);
      bus_start; put_byte(dev_byte(3'd0, 1'b0), ack);
      check("R10 old code before stop", {15'h0, ack}, 16'h1);
      bus_stop;
      bus_start; put_byte(dev_byte(3'd0, 1'b0), ack); bus_stop;
      check("R8 old code rejected", {15'h0, ack}, 16'h0);
      bus_start; put_byte(dev_byte(3'd6, 1'b0), ack); bus_stop;
      check("R8 new code accepted", {15'h0, ack}, 16'h1);

      // R11: start in the middle of a data byte
      write1(3'd6, 16'h0050, 8'h42, ok);
      addr_phase(3'd6, 16'h0050, ok);
      put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
      bus_start; put_byte(dev_byte(3'd6, 1'b0), ack);
      check("R11 device byte after abort", {15'h0, ack}, 16'h1);
      bus_stop;
      read1(3'd6, 16'h0050, d, ok);
      check("R11 partial byte not stored", {8'h0, d}, 16'h0042);

      // R12: stop in the middle of a data byte
      write1(3'd6, 16'h0051, 8'h24, ok);
      addr_phase(3'd6, 16'h0051, ok);
      put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
      bus_stop;
      read1(3'd6, 16'h0051, d, ok);
      check("R12 partial byte not stored", {8'h0, d}, 16'h0024);
      check("R12 next frame acked", {15'h0, ok}, 16'h1);

      // Random byte writes then read-back (R3, R4)
      key_write(8'h00);
      for (int i = 0; i < 16; i++) begin
         logic [15:0] a;
         logic [7:0] v;
         a = 16'($urandom);
         if (a == 16'hFF09) a = 16'hFF08;
         v = 8'($urandom);
         addrs[i] = a;
         write1(3'd6, a, v, ok);
         check("R3 random write ack", {15'h0, ok}, 16'h1);
         model[a[7:0]] = v;
      end
      for (int i = 15; i >= 0; i--) begin
         read1(3'd6, addrs[i], d, ok);
         check("R4 random read", {8'h0, d}, {8'h0, model[addrs[i][7:0]]});
      end

      check("R13 drive changes with SCL high", 16'(r13_bad), 16'd0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule